// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Unit

This block watches the stream of issued instructions from a pipeline front end and adds up the stall penalties those instructions would incur. It does not stall anything and it does not decode anything. Each issue event arrives already classified. The event carries a unit class, up to two source register numbers each with its own valid flag, a destination register number and, for control transfers, a taken flag. A flag marks the first instruction of each new issue group. Instructions within one group are treated as issued in parallel.

Each load marks its destination register in a pending mask. When the next group starts, the pending mask becomes the active mask and the pending mask is emptied. An operand that reads a register set in the active mask is charged a fixed load-use penalty. Control transfers are charged a separate branch penalty when taken. Taken and untaken transfers are also counted.

The four counters saturate at their maximum and are zeroed by a synchronous clear. Performance tooling uses them to attribute lost cycles to load-use hazards versus redirected fetch.

Top module: `stall_acct`

## Requirements
- R1: After reset all four counters read zero and both register masks are empty, so no operand of the first group can stall.
- R2: A load (unit class 4) marks its destination register as pending. That register causes stalls only for instructions of the immediately following group. It no longer stalls in any group after that, unless it is loaded again.
- R3: For exec (class 0), compare (class 1) and MAC (class 2) instructions, each valid source operand whose register is marked in the active mask adds 2 to the load-stall counter.
- R4: A source operand whose valid flag is low never adds a stall, whatever its register number.
- R5: A control transfer (class 3) checks only source A against the active mask, with the same 2-cycle charge. Source B is ignored.
- R6: A taken control transfer adds 2 to the branch-stall counter and 1 to the taken counter.
- R7: An untaken control transfer adds 1 to the untaken counter and leaves the branch-stall and taken counters unchanged.
- R8: Stores (class 5) and the unused class codes 6 and 7 change no counter and mark no register, even when their destination or sources name loaded registers.
- R9: When both sources of an exec, compare or MAC instruction name the same loaded register, the charge is made twice (4 cycles).
- R10: A load and a later instruction in the same group do not hazard: the load's register is only checked from the next group on.
- R11: Every counter saturates at its all-ones value and never wraps.
- R12: A high clear input zeroes all four counters on the next clock edge. It takes priority over a same-cycle issue, but the issue still updates the masks.
- R13: Cycles without a valid issue change neither counters nor masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| iss_valid | input | 1 | An instruction issues this cycle |
| grp_first | input | 1 | Issued instruction opens a new group |
| unit_cls | input | 3 | Unit class code (0 exec, 1 compare, 2 MAC, 3 control transfer, 4 load, 5 store) |
| src_a | input | REG_W | Source A register number |
| src_a_vld | input | 1 | Source A present |
| src_b | input | REG_W | Source B register number |
| src_b_vld | input | 1 | Source B present |
| dst | input | REG_W | Destination register number |
| cti_taken | input | 1 | Control transfer is taken |
| load_stall_cyc | output | CNT_W | Accumulated load-use stall cycles |
| branch_stall_cyc | output | CNT_W | Accumulated taken-branch stall cycles |
| taken_cnt | output | CNT_W | Number of taken control transfers |
| untaken_cnt | output | CNT_W | Number of untaken control transfers |

## Verification
Every counter is a single register fed by the issue inputs of the same cycle. The effect of an issue or clear presented before a rising edge is therefore visible on the outputs right after that edge. The bench drives each event on a falling edge and compares all four counters on the next falling edge against a model updated for exactly that one edge. Mask promotion only shows up through the counts of later issues. The hazard checks for loads therefore span two or three issue events: a load, a group boundary, and a consumer whose counts are compared one edge after it issues.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;

   typedef enum logic [2:0] {
      UC_EXEC  = 3'd0,
      UC_CMP   = 3'd1,
      UC_MAC   = 3'd2,
      UC_CTI   = 3'd3,
      UC_LOAD  = 3'd4,
      UC_STORE = 3'd5
   } unit_cls_e;

   localparam int NUM_OPS = 2;

endpackage

// File: rtl/stall_cls_decode.sv
module stall_cls_decode
   import stall_acct_pkg::*;
(
   input  logic       iss_valid,
   input  logic [2:0] unit_cls,
   input  logic       cti_taken,
   output logic [NUM_OPS-1:0] op_chk_en,
   output logic       is_load,
   output logic       cti_tk,
   output logic       cti_nt
);

   always_comb begin
      op_chk_en = '0;
      is_load   = 1'b0;
      cti_tk    = 1'b0;
      cti_nt    = 1'b0;
      if (iss_valid) begin
         case (unit_cls)
            UC_EXEC, UC_CMP, UC_MAC: op_chk_en = '1;
            UC_CTI: begin
               op_chk_en[0] = 1'b1;
               cti_tk       = cti_taken;
               cti_nt       = ~cti_taken;
            end
            UC_LOAD: is_load = 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/stall_hazard_track.sv
module stall_hazard_track
   import stall_acct_pkg::*;
#(
   parameter  int NREG  = 16,
   localparam int REG_W = $clog2(NREG)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 iss_valid,
   input  logic                 grp_first,
   input  logic                 is_load,
   input  logic [REG_W-1:0]     dst,
   input  logic [REG_W-1:0]     op_reg [NUM_OPS],
   input  logic [NUM_OPS-1:0]   op_vld,
   input  logic [NUM_OPS-1:0]   op_chk_en,
   output logic [NUM_OPS-1:0]   op_hit
);

   logic [NREG-1:0] pend_q, act_q;
   logic [NREG-1:0] eff_act, eff_pend, pend_d;

   always_comb begin
      eff_act  = grp_first ? pend_q : act_q;
      eff_pend = grp_first ? '0 : pend_q;
      pend_d   = eff_pend;
      if (is_load) pend_d[dst] = 1'b1;
   end

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      assign op_hit[i] = op_chk_en[i] & op_vld[i] & eff_act[op_reg[i]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else if (iss_valid) begin
         pend_q <= pend_d;
         act_q  <= eff_act;
      end
   end

endmodule

// File: rtl/stall_sat_ctr.sv
module stall_sat_ctr #(
   parameter int W     = 32,
   parameter int INC_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     cnt
);

   if (INC_W > W) begin : g_bad_width
      $error("stall_sat_ctr: increment wider than counter");
   end

   logic [W:0] sum;
   assign sum = {1'b0, cnt} + {{(W + 1 - INC_W){1'b0}}, inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (sum[W]) cnt <= '1;
      else            cnt <= sum[W-1:0];
   end

endmodule

// File: rtl/stall_acct.sv
module stall_acct
   import stall_acct_pkg::*;
#(
   parameter  int NREG    = 16,
   parameter  int CNT_W   = 32,
   parameter  int PENALTY = 2,
   localparam int REG_W   = $clog2(NREG)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             iss_valid,
   input  logic             grp_first,
   input  logic [2:0]       unit_cls,
   input  logic [REG_W-1:0] src_a,
   input  logic             src_a_vld,
   input  logic [REG_W-1:0] src_b,
   input  logic             src_b_vld,
   input  logic [REG_W-1:0] dst,
   input  logic             cti_taken,
   output logic [CNT_W-1:0] load_stall_cyc,
   output logic [CNT_W-1:0] branch_stall_cyc,
   output logic [CNT_W-1:0] taken_cnt,
   output logic [CNT_W-1:0] untaken_cnt
);

   localparam int LS_MAX = NUM_OPS * PENALTY;
   localparam int INC_W  = $clog2(LS_MAX + 1);

   if (NREG < 2 || (1 << REG_W) != NREG) begin : g_bad_nreg
      $error("stall_acct: NREG must be a power of two of at least 2");
   end
   if (PENALTY < 1) begin : g_bad_pen
      $error("stall_acct: PENALTY must be positive");
   end
   if (CNT_W < INC_W) begin : g_bad_cnt
      $error("stall_acct: CNT_W too narrow for one increment");
   end

   logic [NUM_OPS-1:0] op_chk_en, op_hit;
   logic               is_load, cti_tk, cti_nt;
   logic [REG_W-1:0]   op_reg [NUM_OPS];
   logic [NUM_OPS-1:0] op_vld;

   assign op_reg[0] = src_a;
   assign op_reg[1] = src_b;
   assign op_vld    = {src_b_vld, src_a_vld};

   stall_cls_decode u_dec (
      .iss_valid (iss_valid),
      .unit_cls  (unit_cls),
      .cti_taken (cti_taken),
      .op_chk_en (op_chk_en),
      .is_load   (is_load),
      .cti_tk    (cti_tk),
      .cti_nt    (cti_nt)
   );

   stall_hazard_track #(.NREG(NREG)) u_haz (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .grp_first (grp_first),
      .is_load   (is_load),
      .dst       (dst),
      .op_reg    (op_reg),
      .op_vld    (op_vld),
      .op_chk_en (op_chk_en),
      .op_hit    (op_hit)
   );

   logic [INC_W-1:0] ls_inc, br_inc, tk_inc, nt_inc;

   always_comb begin
      ls_inc = '0;
      for (int i = 0; i < NUM_OPS; i++) begin
         if (op_hit[i]) ls_inc = ls_inc + INC_W'(PENALTY);
      end
      br_inc = cti_tk ? INC_W'(PENALTY) : '0;
      tk_inc = INC_W'(cti_tk);
      nt_inc = INC_W'(cti_nt);
   end

   stall_sat_ctr #(.W(CNT_W), .INC_W(INC_W)) u_ls (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(ls_inc), .cnt(load_stall_cyc));
   stall_sat_ctr #(.W(CNT_W), .INC_W(INC_W)) u_br (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(br_inc), .cnt(branch_stall_cyc));
   stall_sat_ctr #(.W(CNT_W), .INC_W(INC_W)) u_tk (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(tk_inc), .cnt(taken_cnt));
   stall_sat_ctr #(.W(CNT_W), .INC_W(INC_W)) u_nt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(nt_inc), .cnt(untaken_cnt));

endmodule

// File: rtl/stall_acct_chk.sv
module stall_acct_chk #(
   parameter int CNT_W = 32,
   parameter int REG_W = 4
)(
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             iss_valid,
   input logic [2:0]       unit_cls,
   input logic             cti_taken,
   input logic [CNT_W-1:0] load_stall_cyc,
   input logic [CNT_W-1:0] branch_stall_cyc,
   input logic [CNT_W-1:0] taken_cnt,
   input logic [CNT_W-1:0] untaken_cnt
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic is_cti, is_quiet;
   assign is_cti   = iss_valid && unit_cls == 3'd3;
   assign is_quiet = !iss_valid || unit_cls == 3'd4 || unit_cls >= 3'd5;

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (load_stall_cyc == '0 && branch_stall_cyc == '0 &&
               taken_cnt == '0 && untaken_cnt == '0)); // R12

   AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && is_quiet) |=> ($stable(load_stall_cyc) && $stable(branch_stall_cyc) &&
                              $stable(taken_cnt) && $stable(untaken_cnt))); // R8

   AST_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && is_cti && cti_taken && taken_cnt != '1) |=>
         (taken_cnt == $past(taken_cnt) + ONE && $stable(untaken_cnt))); // R6

   AST_UNTAKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && is_cti && !cti_taken) |=>
         ($stable(branch_stall_cyc) && $stable(taken_cnt))); // R7

   AST_LS_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> load_stall_cyc >= $past(load_stall_cyc)); // R11

   AST_TK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> taken_cnt >= $past(taken_cnt)); // R11

endmodule

bind stall_acct stall_acct_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .clr              (clr),
   .iss_valid        (iss_valid),
   .unit_cls         (unit_cls),
   .cti_taken        (cti_taken),
   .load_stall_cyc   (load_stall_cyc),
   .branch_stall_cyc (branch_stall_cyc),
   .taken_cnt        (taken_cnt),
   .untaken_cnt      (untaken_cnt)
);

// File: tb/stall_acct_tb_top.sv
`timescale 1ns/1ps
module stall_acct_tb_top;

   localparam int NREG = 16;
   localparam int CW   = 8;
   localparam int MAXV = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0, iss_valid = 1'b0, grp_first = 1'b0, cti_taken = 1'b0;
   logic [2:0] unit_cls = '0;
   logic [3:0] src_a = '0, src_b = '0, dst = '0;
   logic src_a_vld = 1'b0, src_b_vld = 1'b0;
   logic [CW-1:0] load_stall_cyc, branch_stall_cyc, taken_cnt, untaken_cnt;

   always #2 clk = ~clk;

   stall_acct #(.NREG(NREG), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .iss_valid(iss_valid),
      .grp_first(grp_first), .unit_cls(unit_cls), .src_a(src_a),
      .src_a_vld(src_a_vld), .src_b(src_b), .src_b_vld(src_b_vld),
      .dst(dst), .cti_taken(cti_taken), .load_stall_cyc(load_stall_cyc),
      .branch_stall_cyc(branch_stall_cyc), .taken_cnt(taken_cnt),
      .untaken_cnt(untaken_cnt));

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [NREG-1:0] m_pend = '0, m_act = '0;
   int m_ls = 0, m_br = 0, m_tk = 0, m_nt = 0;

   function automatic int sat(input int v);
      return (v > MAXV) ? MAXV : v;
   endfunction

   task automatic compare(input string tag);
      n_chk++;
      if (load_stall_cyc != CW'(m_ls) || branch_stall_cyc != CW'(m_br) ||
          taken_cnt != CW'(m_tk) || untaken_cnt != CW'(m_nt)) begin
         n_fail++;
         $display("FAIL %s: actual ls=%0d br=%0d tk=%0d nt=%0d expected ls=%0d br=%0d tk=%0d nt=%0d",
                  tag, load_stall_cyc, branch_stall_cyc, taken_cnt, untaken_cnt,
                  m_ls, m_br, m_tk, m_nt);
      end
   endtask

   task automatic step(input bit v, input bit g, input int c, input int sa, input bit sav,
                       input int sb, input bit sbv, input int d, input bit tk,
                       input bit cl, input string tag);
      logic [NREG-1:0] ea, ep;
      int li, bi, ti, ui;
      iss_valid = v; grp_first = g; unit_cls = 3'(c);
      src_a = 4'(sa); src_a_vld = sav; src_b = 4'(sb); src_b_vld = sbv;
      dst = 4'(d); cti_taken = tk; clr = cl;
      ea = g ? m_pend : m_act;
      ep = g ? '0 : m_pend;
      li = 0; bi = 0; ti = 0; ui = 0;
      if (v) begin
         if (c <= 2) begin
            if (sav && ea[sa]) li += 2;
            if (sbv && ea[sb]) li += 2;
         end else if (c == 3) begin
            if (sav && ea[sa]) li += 2;
            if (tk) begin bi = 2; ti = 1; end
            else ui = 1;
         end else if (c == 4) begin
            ep[d] = 1'b1;
         end
         m_act = ea;
         m_pend = ep;
      end
      if (cl) begin
         m_ls = 0; m_br = 0; m_tk = 0; m_nt = 0;
      end else begin
         m_ls = sat(m_ls + li); m_br = sat(m_br + bi);
         m_tk = sat(m_tk + ti); m_nt = sat(m_nt + ui);
      end
      @(negedge clk);
      iss_valid = 1'b0; clr = 1'b0;
      compare(tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1c3b);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 reset");
      // R1: every register reads as not loaded in the first group
      step(1,1,0, 0,1, 15,1, 0,0,0, "R1 empty mask");
      // R2/R3: load r3, consumer in next group
      step(1,1,4, 0,0, 0,0, 3,0,0, "R2 load");
      step(1,1,0, 3,1, 1,1, 0,0,0, "R3 exec hit");
      step(1,0,1, 1,1, 3,1, 0,0,0, "R3 cmp hit B");
      step(1,0,2, 3,1, 3,1, 0,0,0, "R9 double hit");
      step(1,0,0, 3,0, 3,0, 0,0,0, "R4 invalid srcs");
      step(1,1,0, 3,1, 3,1, 0,0,0, "R2 expired");
      // R10: same-group load
      step(1,1,4, 0,0, 0,0, 5,0,0, "R10 load");
      step(1,0,0, 5,1, 5,1, 0,0,0, "R10 same group");
      step(1,1,3, 5,1, 0,0, 0,1,0, "R5 cti hit taken");
      step(1,1,4, 0,0, 0,0, 7,0,0, "R5 load r7");
      step(1,1,3, 0,0, 7,1, 0,0,0, "R5 srcB ignored");
      step(1,0,3, 2,1, 0,0, 0,1,0, "R6 taken");
      step(1,0,3, 2,1, 0,0, 0,0,0, "R7 untaken");
      // R8: store and unused codes
      step(1,1,4, 0,0, 0,0, 9,0,0, "R8 load r9");
      step(1,1,5, 9,1, 9,1, 9,1,0, "R8 store");
      step(1,0,6, 9,1, 9,1, 9,1,0, "R8 code6");
      step(1,0,7, 9,1, 9,1, 9,1,0, "R8 code7");
      step(1,0,0, 9,1, 0,0, 0,0,0, "R8 mask kept");
      step(1,1,0, 9,1, 9,1, 0,0,0, "R8 no record");
      // R13: idle with group flag
      step(1,1,4, 0,0, 0,0, 4,0,0, "R13 load r4");
      step(0,1,0, 4,1, 4,1, 0,1,0, "R13 idle");
      step(1,1,0, 4,1, 0,0, 0,0,0, "R13 mask held");
      // R12: clear with issue; masks keep updating
      step(1,1,4, 4,1, 4,1, 6,0,1, "R12 clr+load");
      step(1,1,0, 6,1, 0,0, 0,0,0, "R12 mask after clr");
      // R11: saturation
      step(1,1,4, 0,0, 0,0, 1,0,0, "R11 load r1");
      step(1,1,0, 1,1, 1,1, 0,0,0, "R11 first");
      for (int i = 0; i < 70; i++) begin
         step(1,0,0, 1,1, 1,1, 0,0,0, "R11 ls sat");
      end
      for (int i = 0; i < 260; i++) begin
         step(1,0,3, 0,0, 0,0, 0,1,0, "R11 tk sat");
      end
      step(1,0,0, 0,0, 0,0, 0,0,1, "R12 clr");
      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         int c, sa, sb, d;
         bit v, g, sav, sbv, tk, cl;
         v   = ($urandom % 8) != 0;
         g   = ($urandom % 3) == 0;
         c   = int'($urandom % 8);
         sa  = int'($urandom % 16);
         sb  = int'($urandom % 16);
         d   = int'($urandom % 16);
         sav = ($urandom % 4) != 0;
         sbv = ($urandom % 4) != 0;
         tk  = $urandom % 2;
         cl  = ($urandom % 60) == 0;
         step(v,g,c, sa,sav, sb,sbv, d,tk,cl, "R3 random");
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule